// File: doc/BRIEF.md
# Filtered Packet Trace Capture Buffer

This block sits beside an on-chip packet crossbar and listens, without taking part, to its command bus and its data bus. During a capture window that software opens with a one-cycle arm pulse, each packet whose transaction type is enabled in a per-type mask is stamped with a free-running cycle count. It is then stored as one fixed-width entry in a small on-die trace memory. A window lasts a programmed number of cycles. When the window expires, the block raises a sticky done flag and keeps whatever it has stored. Software can arm the window again to take a series of short snapshots.

When the trace memory becomes full, the block empties it in store order through a valid/ready drain port toward external memory. For the whole drain it holds a stall request toward the crossbar. Matching packets that arrive while the drain is running, or that find no free slot, are not stored and are counted instead. A global enable turns capture off for the node.

Top module: `pkt_trace_buf`

## Requirements
- R1: Out of reset, `xbar_stall`, `drain_valid`, `capturing` and `win_done` are low, and `fill_level` and `overflow_cnt` are zero.
- R2: While `cfg_enable` is low, an arm pulse opens no window and no packet is stored, so `capturing` and `fill_level` stay at zero.
- R3: An arm pulse with a non-zero `cfg_win_len` of L, sampled at clock edge A, records matching packets sampled at edges A+1 to A+L and none after them. `capturing` is high over exactly those edges.
- R4: At window expiry `win_done` rises and stays high until a `done_clr` pulse. A later arm pulse opens a fresh window.
- R5: A packet is stored only if bit `type` of `cfg_type_mask` is set, where `type` is the packet's type code used as a bit index. Packets of other types change nothing.
- R6: Both buses are sampled on every edge. When both carry a matching packet on the same edge, the command packet is stored first and the data packet takes the next slot.
- R7: An entry is packed MSB first as {source, timestamp, type, word}. Source is 0 for the command bus and 1 for the data bus. Timestamp is the number of clock edges since reset was released, modulo 2^TS_W, counted before the capturing edge.
- R8: On the edge where `fill_level` reaches DEPTH, `xbar_stall` and `drain_valid` go high. Entries then leave in store order, one per edge on which `drain_valid` and `drain_ready` are both high.
- R9: `xbar_stall` stays high until the last stored entry is accepted. On that edge `xbar_stall` falls and `fill_level` returns to zero, and the next capture starts again at the first slot.
- R10: Each matching in-window packet that is not stored adds one to `overflow_cnt`. This covers packets that arrive while a drain is running and a data packet that finds no slot after the command packet took the last one.
- R11: When a window ends before the memory is full, the stored entries stay in place and no drain starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Global capture enable |
| cfg_type_mask | input | 2**TYPE_W | One bit per transaction type; a set bit records that type |
| cfg_win_len | input | WIN_W | Capture window length in cycles |
| win_arm | input | 1 | One-cycle pulse that opens a window |
| done_clr | input | 1 | Clears the window-done flag |
| cmd_valid | input | 1 | Command bus carries a packet |
| cmd_type | input | TYPE_W | Command packet type code |
| cmd_word | input | WORD_W | Command bus word |
| dat_valid | input | 1 | Data bus carries a packet |
| dat_type | input | TYPE_W | Data packet type code |
| dat_word | input | WORD_W | Data bus word |
| drain_ready | input | 1 | External sink accepts an entry |
| drain_valid | output | 1 | An entry is offered on the drain port |
| drain_entry | output | 1+TS_W+TYPE_W+WORD_W | Entry being drained |
| xbar_stall | output | 1 | Stall request toward the crossbar |
| capturing | output | 1 | A capture window is open |
| win_done | output | 1 | Sticky flag: the last window expired |
| fill_level | output | $clog2(DEPTH+1) | Entries held in trace memory |
| overflow_cnt | output | OVF_W | Matching packets that could not be stored |

## Verification
The in-line assertions check these rules on every cycle:
- The fill level never exceeds the depth and sits at full for the whole drain.
- The stall cannot drop before the last entry is accepted, and it does drop on that acceptance with the fill back at zero.
- The overflow count never decreases.
- The window closes when capture is disabled, and the done flag sets at expiry and stays set.

Only the bench scenarios can show the following:
- Which packets a given mask and window keep.
- The command-before-data order within one edge.
- The exact timestamp and field packing of each drained entry.
- The count of packets lost to a running drain.

// File: rtl/ptc_pkg.sv
// Shared definitions for the packet trace capture buffer.
// Assumes: an entry is {source, timestamp, type, word} with source in the MSB.
package ptc_pkg;

    typedef enum logic {
        SRC_CMD = 1'b0,
        SRC_DAT = 1'b1
    } src_e;

    // Number of set flags among two single-bit hits.
    function automatic logic [1:0] pair_count(input logic a, input logic b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/ptc_filter.sv
// Type filter for one snooped bus.
// A packet hits when the bus is valid, capture is gated on, and the mask bit
// indexed by the packet's type code is set.
// Assumes: the mask holds one bit per type code.
module ptc_filter #(
    parameter int TYPE_W = 3
) (
    input  logic                    gate,
    input  logic                    valid,
    input  logic [TYPE_W-1:0]       ptype,
    input  logic [(1<<TYPE_W)-1:0]  mask,
    output logic                    hit
);

    // Qualify the bus packet with the window gate and the type mask.
    always_comb hit = gate && valid && mask[ptype];

endmodule

// File: rtl/ptc_window.sv
// Capture window timer with a sticky done flag.
// An arm pulse with a non-zero length opens the window for that many cycles.
// Expiry sets the done flag, which holds until a clear pulse.
// A low enable closes the window at once and does not set the flag.
module ptc_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             arm,
    input  logic             clr,
    input  logic [WIN_W-1:0] len,
    output logic             open,
    output logic             done
);

    logic [WIN_W-1:0] left_q;
    logic             open_q;
    logic             done_q;
    logic             start;
    logic             expire;

    // Decode the arm request and the last cycle of an open window.
    always_comb begin
        start  = enable && arm && (len != '0);
        expire = enable && !start && open_q && (left_q == WIN_W'(1));
    end

    // Window open flag and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            left_q <= '0;
        end else if (!enable) begin
            open_q <= 1'b0;
        end else if (start) begin
            open_q <= 1'b1;
            left_q <= len;
        end else if (open_q) begin
            left_q <= left_q - WIN_W'(1);
            if (left_q == WIN_W'(1)) open_q <= 1'b0;
        end
    end

    // Sticky done flag: set at expiry, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (expire) done_q <= 1'b1;
        else if (clr)    done_q <= 1'b0;
    end

    assign open = open_q;
    assign done = done_q;

    // R2
    win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !open_q);

    // R4
    win_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && enable && !arm && left_q == WIN_W'(1)) |=> (done_q && !open_q));

    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr) |=> done_q);

endmodule

// File: rtl/ptc_store.sv
// Trace memory with fill, drain and overflow accounting.
// Up to two entries are written per cycle: command first, then data.
// When the memory becomes full it drains from slot 0 upward over a
// valid/ready port and requests a stall until the last entry is accepted.
// Hits that cannot be stored are counted in a saturating overflow counter.
// Assumes: DEPTH is a power of two, at least 2.
module ptc_store
    import ptc_pkg::*;
#(
    parameter int ENTRY_W = 32,
    parameter int DEPTH   = 16,
    parameter int OVF_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit_cmd,
    input  logic                        hit_dat,
    input  logic [ENTRY_W-1:0]          ent_cmd,
    input  logic [ENTRY_W-1:0]          ent_dat,
    input  logic                        drain_ready,
    output logic                        drain_valid,
    output logic [ENTRY_W-1:0]          drain_entry,
    output logic                        stall,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic [OVF_W-1:0]            ovf
);

    localparam int AW  = $clog2(DEPTH);
    localparam int FW  = $clog2(DEPTH+1);
    localparam int OW1 = OVF_W + 1;

    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic [FW-1:0]      cnt_q;
    logic [FW-1:0]      cnt_nxt;
    logic [AW-1:0]      rd_q;
    logic               drain_q;
    logic [OVF_W-1:0]   ovf_q;
    logic               wr_c;
    logic               wr_d;
    logic [AW-1:0]      idx_d;
    logic [1:0]         lost;
    logic [OW1-1:0]     ovf_sum;
    logic               last_take;

    // Decide which hits are stored and how many are lost this cycle.
    always_comb begin
        wr_c      = hit_cmd && !drain_q;
        wr_d      = hit_dat && !drain_q &&
                    ((cnt_q + FW'(wr_c)) < FW'(DEPTH));
        idx_d     = cnt_q[AW-1:0] + AW'(wr_c);
        cnt_nxt   = cnt_q + FW'(wr_c) + FW'(wr_d);
        lost      = pair_count(hit_cmd && !wr_c, hit_dat && !wr_d);
        ovf_sum   = {1'b0, ovf_q} + OW1'(lost);
        last_take = drain_q && drain_ready && (rd_q == AW'(DEPTH-1));
    end

    // Entry storage: command slot first, data slot after it.
    always_ff @(posedge clk) begin
        if (wr_c) mem_q[cnt_q[AW-1:0]] <= ent_cmd;
        if (wr_d) mem_q[idx_d]         <= ent_dat;
    end

    // Fill count, drain state and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rd_q    <= '0;
            drain_q <= 1'b0;
        end else if (drain_q) begin
            if (last_take) begin
                drain_q <= 1'b0;
                rd_q    <= '0;
                cnt_q   <= '0;
            end else if (drain_ready) begin
                rd_q <= rd_q + AW'(1);
            end
        end else begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == FW'(DEPTH)) drain_q <= 1'b1;
        end
    end

    // Saturating overflow counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_q <= '0;
        else if (ovf_sum[OVF_W]) ovf_q <= '1;
        else                     ovf_q <= ovf_sum[OVF_W-1:0];
    end

    assign drain_valid = drain_q;
    assign drain_entry = mem_q[rd_q];
    assign stall       = drain_q;
    assign fill        = cnt_q;
    assign ovf         = ovf_q;

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FW'(DEPTH));

    // R8
    full_while_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_q |-> (cnt_q == FW'(DEPTH)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q && !last_take) |=> drain_q);

    // R9
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> (!drain_q && cnt_q == '0 && rd_q == '0));

    // R10
    ovf_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q >= $past(ovf_q));

endmodule

// File: rtl/pkt_trace_buf.sv
// Filtered packet trace capture buffer (top).
// Snoops the crossbar command and data buses and filters each bus by type
// inside an armed window. Matching packets are stamped with a free-running
// cycle count and stored. A full memory drains through a valid/ready port
// while the crossbar is stalled.
// Assumes: both buses present at most one packet per cycle each.
module pkt_trace_buf
    import ptc_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter int WORD_W = 16,
    parameter int TS_W   = 12,
    parameter int DEPTH  = 16,
    parameter int WIN_W  = 8,
    parameter int OVF_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_enable,
    input  logic [(1<<TYPE_W)-1:0]          cfg_type_mask,
    input  logic [WIN_W-1:0]                cfg_win_len,
    input  logic                            win_arm,
    input  logic                            done_clr,
    input  logic                            cmd_valid,
    input  logic [TYPE_W-1:0]               cmd_type,
    input  logic [WORD_W-1:0]               cmd_word,
    input  logic                            dat_valid,
    input  logic [TYPE_W-1:0]               dat_type,
    input  logic [WORD_W-1:0]               dat_word,
    input  logic                            drain_ready,
    output logic                            drain_valid,
    output logic [TS_W+TYPE_W+WORD_W:0]     drain_entry,
    output logic                            xbar_stall,
    output logic                            capturing,
    output logic                            win_done,
    output logic [$clog2(DEPTH+1)-1:0]      fill_level,
    output logic [OVF_W-1:0]                overflow_cnt
);

    localparam int ENTRY_W = 1 + TS_W + TYPE_W + WORD_W;
    localparam int NBUS    = 2;

    logic [TS_W-1:0]    ts_q;
    logic               win_open;
    logic [NBUS-1:0]    bus_v;
    logic [TYPE_W-1:0]  bus_t [NBUS];
    logic [NBUS-1:0]    bus_hit;
    logic [ENTRY_W-1:0] ent_cmd;
    logic [ENTRY_W-1:0] ent_dat;

    // Free-running timestamp, counts edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + TS_W'(1);
    end

    ptc_window #(.WIN_W(WIN_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_enable),
        .arm    (win_arm),
        .clr    (done_clr),
        .len    (cfg_win_len),
        .open   (win_open),
        .done   (win_done)
    );

    // Gather both snooped buses for the per-bus filters.
    always_comb begin
        bus_v    = {dat_valid, cmd_valid};
        bus_t[0] = cmd_type;
        bus_t[1] = dat_type;
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_tap
        ptc_filter #(.TYPE_W(TYPE_W)) u_flt (
            .gate  (cfg_enable && win_open),
            .valid (bus_v[b]),
            .ptype (bus_t[b]),
            .mask  (cfg_type_mask),
            .hit   (bus_hit[b])
        );
    end

    // Pack one entry per bus with the current timestamp.
    always_comb begin
        ent_cmd = {SRC_CMD, ts_q, cmd_type, cmd_word};
        ent_dat = {SRC_DAT, ts_q, dat_type, dat_word};
    end

    ptc_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_cmd     (bus_hit[0]),
        .hit_dat     (bus_hit[1]),
        .ent_cmd     (ent_cmd),
        .ent_dat     (ent_dat),
        .drain_ready (drain_ready),
        .drain_valid (drain_valid),
        .drain_entry (drain_entry),
        .stall       (xbar_stall),
        .fill        (fill_level),
        .ovf         (overflow_cnt)
    );

    assign capturing = win_open;

    // R2
    no_store_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !xbar_stall) |=> $stable(fill_level));

    // R5
    no_store_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !xbar_stall) |=> $stable(fill_level));

endmodule

// File: tb/pkt_trace_buf_tb.sv
`timescale 1ns/1ps
module pkt_trace_buf_tb;

    localparam int TYPE_W  = 3;
    localparam int WORD_W  = 16;
    localparam int TS_W    = 12;
    localparam int DEPTH   = 16;
    localparam int WIN_W   = 8;
    localparam int OVF_W   = 8;
    localparam int ENTRY_W = 1 + TS_W + TYPE_W + WORD_W;
    localparam int FW      = $clog2(DEPTH+1);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     cfg_enable = 1'b0;
    logic [(1<<TYPE_W)-1:0]   cfg_type_mask = '0;
    logic [WIN_W-1:0]         cfg_win_len = '0;
    logic                     win_arm = 1'b0;
    logic                     done_clr = 1'b0;
    logic                     cmd_valid = 1'b0;
    logic [TYPE_W-1:0]        cmd_type = '0;
    logic [WORD_W-1:0]        cmd_word = '0;
    logic                     dat_valid = 1'b0;
    logic [TYPE_W-1:0]        dat_type = '0;
    logic [WORD_W-1:0]        dat_word = '0;
    logic                     drain_ready = 1'b0;
    logic                     drain_valid;
    logic [ENTRY_W-1:0]       drain_entry;
    logic                     xbar_stall;
    logic                     capturing;
    logic                     win_done;
    logic [FW-1:0]            fill_level;
    logic [OVF_W-1:0]         overflow_cnt;

    pkt_trace_buf #(
        .TYPE_W(TYPE_W), .WORD_W(WORD_W), .TS_W(TS_W),
        .DEPTH(DEPTH), .WIN_W(WIN_W), .OVF_W(OVF_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_type_mask(cfg_type_mask), .cfg_win_len(cfg_win_len),
        .win_arm(win_arm), .done_clr(done_clr),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_word(cmd_word),
        .dat_valid(dat_valid), .dat_type(dat_type), .dat_word(dat_word),
        .drain_ready(drain_ready), .drain_valid(drain_valid),
        .drain_entry(drain_entry), .xbar_stall(xbar_stall),
        .capturing(capturing), .win_done(win_done),
        .fill_level(fill_level), .overflow_cnt(overflow_cnt)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_vec  = 0;
    int n_fail = 0;
    int tb_edges = 0;
    int tb_win = 0;
    int exp_fill = 0;
    int exp_ovf = 0;
    int pops = 0;
    bit exp_drain = 1'b0;
    bit rdy_en = 1'b0;
    bit after_last = 1'b0;
    bit finished = 1'b0;
    logic [ENTRY_W-1:0] exp_q [$];

    // Edge counter mirroring the timestamp rule of R7.
    always @(posedge clk) if (rst_n) tb_edges <= tb_edges + 1;

    // Sink readiness: two of every three cycles when enabled.
    always @(negedge clk) drain_ready <= rdy_en && (tb_edges % 3 != 0);

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops expected entries on each drain handshake (R6, R7, R8, R9).
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (after_last) begin
                after_last = 1'b0;
                check("R9 stall released after last entry", xbar_stall, 0);
                check("R9 fill zero after drain", fill_level, 0);
            end
            if (drain_valid && drain_ready) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected drained entry", drain_entry, 0);
                end else begin
                    logic [ENTRY_W-1:0] e;
                    e = exp_q.pop_front();
                    check("R7 drained entry", drain_entry, e);
                end
                pops++;
                if (pops == DEPTH) after_last = 1'b1;
            end
        end
    end

    // Bench-side model for one stored hit.
    task automatic model_hit(input bit src, input logic [TYPE_W-1:0] t,
                             input logic [WORD_W-1:0] w, input int ts);
        if (exp_drain || exp_fill >= DEPTH) begin
            exp_ovf++;
        end else begin
            exp_q.push_back({src, TS_W'(ts), t, w});
            exp_fill++;
        end
    endtask

    // Driver: one cycle of bus traffic, with the expected result queued.
    task automatic send(input bit cv, input logic [TYPE_W-1:0] ct, input logic [WORD_W-1:0] cw,
                        input bit dv, input logic [TYPE_W-1:0] dt, input logic [WORD_W-1:0] dw);
        bit open;
        @(negedge clk);
        win_arm = 1'b0; done_clr = 1'b0;
        cmd_valid = cv; cmd_type = ct; cmd_word = cw;
        dat_valid = dv; dat_type = dt; dat_word = dw;
        open = cfg_enable && tb_win > 0;
        if (open && cv && cfg_type_mask[ct]) model_hit(1'b0, ct, cw, tb_edges);
        if (open && dv && cfg_type_mask[dt]) model_hit(1'b1, dt, dw, tb_edges);
        if (exp_fill == DEPTH) exp_drain = 1'b1;
        if (tb_win > 0) tb_win--;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic arm(input int len);
        @(negedge clk);
        cmd_valid = 1'b0; dat_valid = 1'b0; done_clr = 1'b0;
        cfg_win_len = WIN_W'(len);
        win_arm = 1'b1;
        if (cfg_enable && len != 0) tb_win = len;
        else if (tb_win > 0) tb_win--;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cfg_type_mask = 8'b1010_0110;   // types 1, 2, 5, 7 recorded
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 stall", xbar_stall, 0);
        check("R1 drain_valid", drain_valid, 0);
        check("R1 capturing", capturing, 0);
        check("R1 done", win_done, 0);
        check("R1 fill", fill_level, 0);
        check("R1 overflow", overflow_cnt, 0);

        // R2: disabled node ignores arm and traffic
        arm(5);
        for (int i = 0; i < 5; i++) send(1'b1, 3'd1, 16'h1000 + 16'(i), 1'b1, 3'd2, 16'h2000 + 16'(i));
        idle(1);
        check("R2 no window while disabled", capturing, 0);
        check("R2 nothing stored while disabled", fill_level, 0);
        check("R2 no done while disabled", win_done, 0);

        // R3, R5, R6: window of 6 with a type mix on both buses
        cfg_enable = 1'b1;
        arm(6);
        send(1'b1, 3'd1, 16'hA001, 1'b1, 3'd2, 16'hB001);   // both kept, cmd first (R6)
        send(1'b1, 3'd0, 16'hA002, 1'b1, 3'd5, 16'hB002);   // cmd filtered (R5)
        check("R3 capturing inside window", capturing, 1);
        send(1'b1, 3'd3, 16'hA003, 1'b0, 3'd7, 16'hB003);   // filtered, data idle
        send(1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'hB004);   // filtered (R5)
        send(1'b1, 3'd7, 16'hA005, 1'b1, 3'd6, 16'hB005);
        send(1'b1, 3'd2, 16'hA006, 1'b1, 3'd1, 16'hB006);   // last window edge
        send(1'b1, 3'd1, 16'hA007, 1'b1, 3'd2, 16'hB007);   // after window (R3)
        send(1'b1, 3'd5, 16'hA008, 1'b0, 3'd0, 16'h0000);   // after window (R3)
        idle(1);
        check("R3 R5 fill after first window", fill_level, exp_fill);
        check("R3 window closed", capturing, 0);
        check("R4 done set at expiry", win_done, 1);
        idle(3);
        check("R11 contents kept after window", fill_level, exp_fill);
        check("R11 no drain before full", drain_valid, 0);
        check("R4 done held", win_done, 1);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        @(negedge clk);
        check("R4 done cleared", win_done, 0);

        // R8, R10: re-arm, fill to one below full, then both buses hit
        arm(30);
        for (int i = 0; exp_fill < DEPTH - 1; i++) send(1'b1, 3'd2, 16'hC000 + 16'(i), 1'b0, '0, '0);
        send(1'b1, 3'd5, 16'hD001, 1'b1, 3'd7, 16'hD002);    // data finds no slot
        idle(1);
        check("R8 stall on full", xbar_stall, 1);
        check("R8 drain offered", drain_valid, 1);
        check("R10 lost data packet counted", overflow_cnt, exp_ovf);
        send(1'b1, 3'd1, 16'hE001, 1'b0, '0, '0);
        send(1'b1, 3'd0, 16'hE002, 1'b1, 3'd2, 16'hE003);
        send(1'b1, 3'd7, 16'hE004, 1'b1, 3'd3, 16'hE005);
        idle(1);
        check("R10 overflow during drain", overflow_cnt, exp_ovf);
        check("R9 stall held while sink idle", xbar_stall, 1);
        check("R8 fill full during drain", fill_level, DEPTH);

        rdy_en = 1'b1;
        for (int i = 0; i < 200 && xbar_stall; i++) idle(1);
        idle(2);
        rdy_en = 1'b0;
        exp_drain = 1'b0; exp_fill = 0;
        check("R8 all entries drained", pops, DEPTH);
        check("R8 nothing left expected", exp_q.size(), 0);
        check("R9 stall low after drain", xbar_stall, 0);

        // R9: capture restarts at slot zero
        arm(3);
        send(1'b1, 3'd1, 16'hF001, 1'b0, '0, '0);
        send(1'b0, '0, '0, 1'b1, 3'd5, 16'hF002);
        idle(2);
        check("R9 refill from zero", fill_level, 2);
        finish_run();
    end

endmodule